// File: doc/BRIEF.md
# Deferred-Load Split Event Counter Bank

The block holds four physical 32-bit event counters behind a simple register port. Each physical counter can run whole or be split into two independent 16-bit halves by its own mode bit in a control register. There are eight logical counter indices, one 1-bit event input for each. When a counter is split, the lower four indices address the upper halves and the upper four indices address the lower halves.

Software never loads a running counter directly. A counter write goes into a holding latch. The latched value moves into the live counter only when the control register is written with its enable bit set, and this holds even if the monitor is already running. Reads always return the live count. Each counter, or each half, sets a sticky status bit when it wraps, and software clears that bit by writing a one to it. Register data sits in the upper 32 bits of a 64-bit bus word.

Address map: 0 to 7 are the logical counters, 8 is the control register and 9 is the status register. Control register bits, as seen in the 32-bit register value (bus bits 63:32): bit 0 is enable, and bit 1+p is the split bit for physical counter p (1 means two 16-bit halves). Status register: bit i is the wrap flag of logical counter i.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset the live counters, the latches, the control register and the status register are zero, and every register reads as zero.
- R2: A counter write changes only the holding latch. A counter read returns the live value and never a pending latch value.
- R3: A control write with bit 0 set copies every pending latch into its live counter and clears the pending state. This also applies when enable is already set.
- R4: With split bit p clear, logical index p addresses all 32 bits of physical counter p and counts its event input. Writes to index p+4 are ignored, event input p+4 is ignored, and index p+4 reads as zero.
- R5: With split bit p set, index p is the upper half and index p+4 is the lower half of physical counter p. Each half counts its own event input and no carry passes between the halves.
- R6: A 16-bit write leaves the other half of the same physical counter unchanged. The other half is taken from the pending latch if one exists, otherwise from the live value.
- R7: With enable clear, no counter changes, and the live values are kept.
- R8: The register value travels in bus bits 63:32. Write bits 31:0 are ignored and read bits 31:0 are zero.
- R9: A wrap from all ones to zero sets status bit i of logical counter i. In 32-bit mode this is bit p. Writing 1 to a status bit clears it.
- R10: When a commit and an event hit the same counter in the same cycle, the committed value is loaded and that event is dropped.
- R11: The read data and rd_valid appear in the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address for the read or write |
| wdata | input | 64 | Write data; the register value is in bits 63:32 |
| event_in | input | 8 | One event input per logical counter |
| rdata | output | 64 | Registered read data; bits 31:0 are zero |
| rd_valid | output | 1 | High for one cycle when rdata holds a read result |

## Verification
The assertions assume that a read and a write never target the block in the same cycle. A counter write and a commit therefore never coincide. The assertion that a counter write leaves the live value alone only applies in cycles with no event asserted. The stimulus issues one register access at a time and holds the event inputs low during every table-driven access. Events are raised only in the directed sequences, and in those sequences coincident events and commits are set up on purpose.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int PCB_REG_W = 32;

  typedef enum logic [1:0] {SEL_CTR, SEL_CTRL, SEL_STAT, SEL_NONE} pcb_sel_e;

  function automatic pcb_sel_e pcb_decode(input int a, input int nlog);
    if (a < nlog) return SEL_CTR;
    else if (a == nlog) return SEL_CTRL;
    else if (a == nlog + 1) return SEL_STAT;
    else return SEL_NONE;
  endfunction
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          split,
  input  logic          commit,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW-1:0] wval,
  input  logic          ev_hi,
  input  logic          ev_lo,
  output logic [CW-1:0] live_o,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;
  localparam logic [CW-1:0] ONE_W = 1;
  localparam logic [HW-1:0] ONE_H = 1;

  logic [CW-1:0] live_q, latch_q, base;
  logic          pend_q, load, cnt_hi, cnt_lo, wr_acc;

  assign base   = pend_q ? latch_q : live_q;
  assign load   = commit && pend_q;
  assign cnt_hi = enable && !load && ev_hi;
  assign cnt_lo = enable && !load && split && ev_lo;
  assign wr_acc = wr_hi || (wr_lo && split);
  assign ovf_hi = cnt_hi && (split ? (&live_q[CW-1:HW]) : (&live_q));
  assign ovf_lo = cnt_lo && (&live_q[HW-1:0]);
  assign live_o = live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (load) begin
        live_q <= latch_q;
      end else if (!split) begin
        if (cnt_hi) live_q <= live_q + ONE_W;
      end else begin
        if (cnt_hi) live_q[CW-1:HW] <= live_q[CW-1:HW] + ONE_H;
        if (cnt_lo) live_q[HW-1:0]  <= live_q[HW-1:0] + ONE_H;
      end

      if (wr_hi)
        latch_q <= split ? {wval[HW-1:0], base[HW-1:0]} : wval;
      else if (wr_lo && split)
        latch_q <= {base[CW-1:HW], wval[HW-1:0]};

      if (commit) pend_q <= 1'b0;
      else if (wr_acc) pend_q <= 1'b1;
    end
  end

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable && !commit) |=> $stable(live_q));

  assert_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (split && !ev_lo && !commit) |=> $stable(live_q[HW-1:0]));

  assert_commit_clears_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> !pend_q);

  assert_write_defers_R2: assert property (@(posedge clk) disable iff (rst)
    ((wr_hi || wr_lo) && !ev_hi && !ev_lo) |=> $stable(live_q));
endmodule

// File: rtl/pcb_regs.sv
module pcb_regs #(
  parameter int NUM_PHYS = 4,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_ctrl,
  input  logic                           wr_stat,
  input  logic [REG_W-1:0]               wval,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [NUM_PHYS-1:0][REG_W-1:0] live,
  input  logic [2*NUM_PHYS-1:0]          ovf_vec,
  output logic                           enable,
  output logic [NUM_PHYS-1:0]            split,
  output logic [2*REG_W-1:0]             rdata,
  output logic                           rd_valid
);
  import pcb_pkg::*;
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int PW      = $clog2(NUM_PHYS);
  localparam int HW      = REG_W / 2;

  logic [NUM_PHYS:0]    ctrl_q;
  logic [NUM_LOG-1:0]   stat_q, clr_mask, keep;
  logic [REG_W-1:0]     rd_word;
  logic [PW-1:0]        phys_sel;
  pcb_sel_e             sel;
  logic                 unused_wval_hi;

  assign enable   = ctrl_q[0];
  assign split    = ctrl_q[NUM_PHYS:1];
  assign clr_mask = wr_stat ? wval[NUM_LOG-1:0] : '0;
  assign keep     = stat_q & ~clr_mask;
  assign phys_sel = rd_addr[PW-1:0];
  assign sel      = pcb_decode(int'(rd_addr), NUM_LOG);
  assign unused_wval_hi = ^wval[REG_W-1:NUM_LOG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wval[NUM_PHYS:0];
      stat_q <= keep | ovf_vec;
    end
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTR: begin
        if (split[phys_sel])
          rd_word = rd_addr[PW] ? {{HW{1'b0}}, live[phys_sel][HW-1:0]}
                                : {{HW{1'b0}}, live[phys_sel][REG_W-1:HW]};
        else if (!rd_addr[PW])
          rd_word = live[phys_sel];
      end
      SEL_CTRL: rd_word = {{(REG_W-NUM_PHYS-1){1'b0}}, ctrl_q};
      SEL_STAT: rd_word = {{(REG_W-NUM_LOG){1'b0}}, stat_q};
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= {rd_word, {REG_W{1'b0}}};
    end
  end

  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(keep)) == $past(keep)));

  assert_low_half_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rdata[REG_W-1:0] == '0));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_PHYS = 4,
  parameter int REG_W    = pcb_pkg::PCB_REG_W,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*REG_W-1:0]    wdata,
  input  logic [2*NUM_PHYS-1:0] event_in,
  output logic [2*REG_W-1:0]    rdata,
  output logic                  rd_valid
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int BUS_W   = 2 * REG_W;

  logic [REG_W-1:0]               wval;
  logic [NUM_PHYS-1:0][REG_W-1:0] live;
  logic [NUM_LOG-1:0]             ovf_vec;
  logic [NUM_PHYS-1:0]            split, wr_hi, wr_lo, ovf_hi, ovf_lo;
  logic                           enable, wr_ctrl, wr_stat, commit;
  logic                           unused_wlow;

  assign wval        = wdata[BUS_W-1:REG_W];
  assign unused_wlow = ^wdata[REG_W-1:0];
  assign wr_ctrl     = wr_en && (addr == ADDR_W'(NUM_LOG));
  assign wr_stat     = wr_en && (addr == ADDR_W'(NUM_LOG + 1));
  assign commit      = wr_ctrl && wval[0];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_phys
    assign wr_hi[g] = wr_en && (addr == ADDR_W'(g));
    assign wr_lo[g] = wr_en && (addr == ADDR_W'(g + NUM_PHYS));
    assign ovf_vec[g]            = ovf_hi[g];
    assign ovf_vec[g + NUM_PHYS] = ovf_lo[g];

    pcb_counter #(.CW(REG_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .enable (enable),
      .split  (split[g]),
      .commit (commit),
      .wr_hi  (wr_hi[g]),
      .wr_lo  (wr_lo[g]),
      .wval   (wval),
      .ev_hi  (event_in[g]),
      .ev_lo  (event_in[g + NUM_PHYS]),
      .live_o (live[g]),
      .ovf_hi (ovf_hi[g]),
      .ovf_lo (ovf_lo[g])
    );
  end

  pcb_regs #(.NUM_PHYS(NUM_PHYS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_stat  (wr_stat),
    .wval     (wval),
    .rd_en    (rd_en),
    .rd_addr  (addr),
    .live     (live),
    .ovf_vec  (ovf_vec),
    .enable   (enable),
    .split    (split),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  event_in = '0;
  logic [63:0] rdata;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  perf_counter_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .event_in(event_in), .rdata(rdata), .rd_valid(rd_valid)
  );

  localparam logic [3:0] A_CTRL = 4'd8;
  localparam logic [3:0] A_STAT = 4'd9;
  localparam int NV = 20;
  // {op(1: read-check, 0: write), req(4), addr(4), data(32)}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 4'd1, A_CTRL, 32'h0000_0000},  // R1 control zero
    {1'b1, 4'd1, 4'd0,   32'h0000_0000},  // R1 counter zero
    {1'b1, 4'd1, A_STAT, 32'h0000_0000},  // R1 status zero
    {1'b0, 4'd2, 4'd0,   32'h1234_5678},
    {1'b1, 4'd2, 4'd0,   32'h0000_0000},  // R2 latch not visible
    {1'b0, 4'd3, A_CTRL, 32'h0000_0001},
    {1'b1, 4'd3, 4'd0,   32'h1234_5678},  // R3 committed
    {1'b1, 4'd8, A_CTRL, 32'h0000_0001},  // R8 low bits of write ignored
    {1'b0, 4'd5, A_CTRL, 32'h0000_0003},
    {1'b1, 4'd5, 4'd0,   32'h0000_1234},  // R5 upper half
    {1'b1, 4'd5, 4'd4,   32'h0000_5678},  // R5 lower half
    {1'b0, 4'd2, 4'd4,   32'h0000_AAAA},
    {1'b1, 4'd2, 4'd4,   32'h0000_5678},  // R2 live shown
    {1'b0, 4'd3, A_CTRL, 32'h0000_0003},
    {1'b1, 4'd3, 4'd4,   32'h0000_AAAA},  // R3 commit while enabled
    {1'b1, 4'd6, 4'd0,   32'h0000_1234},  // R6 other half kept
    {1'b0, 4'd4, 4'd5,   32'h0000_BEEF},
    {1'b0, 4'd4, A_CTRL, 32'h0000_0003},
    {1'b1, 4'd4, 4'd5,   32'h0000_0000},  // R4 index 5 reads zero
    {1'b1, 4'd4, 4'd1,   32'h0000_0000}   // R4 write to 5 ignored
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = {v, 32'hDEAD_BEEF};
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input string tag, input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " rd_valid"}, {63'd0, rd_valid}, 64'd1);
    check(tag, rdata, {v, 32'h0});
  endtask

  task automatic pulse_events(input logic [7:0] ev, input int n);
    @(negedge clk);
    event_in = ev;
    repeat (n) @(negedge clk);
    event_in = '0;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40])
        reg_read($sformatf("R%0d row %0d", VEC[i][39:36], i), VEC[i][35:32], VEC[i][31:0]);
      else
        reg_write(VEC[i][35:32], VEC[i][31:0]);
    end

    // R11: rd_valid drops the cycle after a read ends
    @(negedge clk);
    check("R11 rd_valid idle", {63'd0, rd_valid}, 64'd0);

    // R1: reset clears everything set above
    do_reset();
    reg_read("R1 ctrl after reset", A_CTRL, 32'h0);
    reg_read("R1 ctr4 after reset", 4'd4, 32'h0);

    // R4/R9: 32-bit count across a wrap; event 5 ignored
    reg_write(4'd1, 32'hFFFF_FFFE);
    reg_write(A_CTRL, 32'h1);
    pulse_events(8'h22, 3);
    reg_read("R4 ctr1 wrapped", 4'd1, 32'h0000_0001);
    reg_read("R9 wrap status bit1", A_STAT, 32'h0000_0002);
    reg_write(A_STAT, 32'h2);
    reg_read("R9 status cleared", A_STAT, 32'h0);

    // R5/R6: split phys1, lower half wraps without carry
    reg_write(A_CTRL, 32'h5);
    reg_read("R5 upper after split", 4'd1, 32'h0);
    reg_read("R5 lower after split", 4'd5, 32'h0000_0001);
    reg_write(4'd5, 32'h0000_FFFF);
    reg_write(A_CTRL, 32'h5);
    pulse_events(8'h20, 1);
    reg_read("R5 lower wrapped", 4'd5, 32'h0);
    reg_read("R5 no carry upper", 4'd1, 32'h0);
    reg_read("R9 split wrap bit5", A_STAT, 32'h0000_0020);
    pulse_events(8'h02, 2);
    reg_read("R5 upper counts", 4'd1, 32'h0000_0002);
    reg_read("R6 lower unchanged", 4'd5, 32'h0);

    // R10: commit and events in the same cycle
    reg_write(4'd1, 32'h0000_0010);
    @(negedge clk);
    wr_en = 1'b1; addr = A_CTRL; wdata = {32'h5, 32'h0}; event_in = 8'h22;
    @(negedge clk);
    wr_en = 1'b0; event_in = '0;
    reg_read("R10 commit wins upper", 4'd1, 32'h0000_0010);
    reg_read("R10 commit wins lower", 4'd5, 32'h0);

    // R7: disable keeps values and stops counting
    reg_write(A_CTRL, 32'h4);
    pulse_events(8'h22, 2);
    reg_read("R7 ctrl disabled", A_CTRL, 32'h4);
    reg_read("R7 upper held", 4'd1, 32'h0000_0010);
    reg_read("R7 lower held", 4'd5, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule